// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions in program order from the moment they are dispatched until they retire. Each instruction gets a slot when it is dispatched, and that slot records what kind of instruction it is and where its result will go. When the execution units finish, they write the result into the slot by tag. Retirement only ever looks at the oldest slot. Once that slot holds a finished result, the block drives exactly one commit action: a register-file write, a memory write, or a branch check. Nothing becomes architectural before this point, so speculative work leaves no trace until it is no longer speculative.

A finished branch can report that it was predicted wrongly. In that case it retires, drives its true target out on the redirect port, and every slot younger than it is discarded. A finished instruction can also report an exception. The exception does nothing while the instruction waits in the buffer. When the instruction becomes the oldest slot, it retires without any write, raises the trap output and empties the buffer.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `full` is 0, `alloc_tag` is 0 and no commit output is active.
- R2: A dispatch request with `full` low is accepted and takes the tag shown on `alloc_tag`; successive accepted dispatches take tags that increase by one, modulo the depth.
- R3: `full` is 1 exactly when the buffer holds DEPTH entries; a dispatch request while `full` is 1 is discarded and leaves `alloc_tag` unchanged.
- R4: Only the oldest entry can retire, and only after its result has been written; a finished younger entry waits, and at most one entry retires per cycle.
- R5: Retiring a register entry (kind code 0) drives `rf_we` high, with `rf_addr` equal to its destination field and `rf_data` equal to its result.
- R6: Retiring a store entry (kind code 1) drives `mem_we` high, with `mem_slot` equal to its destination field and `mem_data` equal to its result; `rf_we` stays low.
- R7: Retiring a correctly predicted branch (kind code 2) drives neither write port nor `redirect_valid`.
- R8: Retiring a branch whose completion carried `cmp_mispredict` drives `redirect_valid` with `redirect_pc` equal to its result. All younger entries are discarded and the next dispatch takes the tag that follows the branch.
- R9: Retiring an entry whose completion carried `cmp_except` drives `trap_valid` with `commit_tag` equal to its tag. It drives no write port and no redirect, even for a mispredicted branch. The buffer is emptied.
- R10: A completion whose tag names no live entry has no effect, so a later dispatch that reuses that tag is not ready until it completes itself.
- R11: A dispatch request made in the cycle of a redirect or trap is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch request |
| alloc_kind | input | 2 | Entry kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | DEST_W | Destination register or store slot |
| alloc_tag | output | TAG_W | Tag that the next accepted dispatch takes |
| full | output | 1 | All DEPTH entries are occupied |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Tag of the finished entry |
| cmp_value | input | DATA_W | Result, or the actual target for a branch |
| cmp_mispredict | input | 1 | Branch was predicted wrongly |
| cmp_except | input | 1 | Instruction raised an exception |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring entry |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | DEST_W | Register file write address |
| rf_data | output | DATA_W | Register file write data |
| mem_we | output | 1 | Memory write enable |
| mem_slot | output | DEST_W | Store slot of the memory write |
| mem_data | output | DATA_W | Memory write data |
| redirect_valid | output | 1 | Refetch request after a mispredicted branch |
| redirect_pc | output | DATA_W | Refetch address |
| trap_valid | output | 1 | Exception taken at retirement |

## Verification
The hardest state to reach from the ports is a slot freed by a flush that still receives a late completion, followed by a new dispatch that reuses the same tag. The stimulus first completes two entries behind a wrongly predicted branch and then retires the branch. It then completes one of the discarded tags, dispatches into that tag again, and checks that the new entry does not retire. The full-buffer stall and a dispatch arriving in the flush cycle are reached by similar directed sequences after the table of mixed register, store and branch entries has been run out of order.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      KIND_REG    = 2'd0,
      KIND_STORE  = 2'd1,
      KIND_BRANCH = 2'd2
   } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter  int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic             commit_fire,
   input  logic             flush,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count
);
   // Head, tail and occupancy; depth is a power of two so pointers wrap naturally
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         // the flushing entry retires; everything behind it is dropped
         head  <= head + 1'b1;
         tail  <= head + 1'b1;
         count <= '0;
      end else begin
         head  <= head + TAG_W'(commit_fire);
         tail  <= tail + TAG_W'(alloc_fire);
         count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
      end
   end
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
   import rob_pkg::*;
#(
   parameter  int DEPTH  = 8,
   parameter  int DATA_W = 32,
   parameter  int DEST_W = 5,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_fire,
   input  logic [TAG_W-1:0]  alloc_idx,
   input  rob_kind_e         alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   input  logic              cmp_valid,
   input  logic [TAG_W-1:0]  cmp_idx,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              cmp_misp,
   input  logic              cmp_exc,
   input  logic              retire,
   input  logic              flush,
   input  logic [TAG_W-1:0]  head_idx,
   output logic              head_valid,
   output logic              head_ready,
   output rob_kind_e         head_kind,
   output logic [DEST_W-1:0] head_dest,
   output logic [DATA_W-1:0] head_value,
   output logic              head_misp,
   output logic              head_exc
);
   logic [DEPTH-1:0]  live_vec;
   logic [DEPTH-1:0]  done_vec;
   logic [DEPTH-1:0]  misp_vec;
   logic [DEPTH-1:0]  exc_vec;
   logic [1:0]        kind_arr [DEPTH];
   logic [DEST_W-1:0] dest_arr [DEPTH];
   logic [DATA_W-1:0] val_arr  [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              live_q, done_q, misp_q, exc_q;
      logic [1:0]        kind_q;
      logic [DEST_W-1:0] dest_q;
      logic [DATA_W-1:0] val_q;
      logic              hit_alloc, hit_cmp, hit_ret;

      assign hit_alloc = alloc_fire && (alloc_idx == TAG_W'(g));
      assign hit_cmp   = cmp_valid && live_q && (cmp_idx == TAG_W'(g));
      assign hit_ret   = retire && (head_idx == TAG_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= 1'b0;
            done_q <= 1'b0;
            misp_q <= 1'b0;
            exc_q  <= 1'b0;
            kind_q <= '0;
            dest_q <= '0;
            val_q  <= '0;
         end else begin
            if (flush)          live_q <= 1'b0;
            else if (hit_alloc) live_q <= 1'b1;
            else if (hit_ret)   live_q <= 1'b0;

            if (hit_alloc) begin
               kind_q <= alloc_kind;
               dest_q <= alloc_dest;
               done_q <= 1'b0;
               misp_q <= 1'b0;
               exc_q  <= 1'b0;
            end else if (hit_cmp) begin
               val_q  <= cmp_value;
               done_q <= 1'b1;
               misp_q <= cmp_misp;
               exc_q  <= cmp_exc;
            end
         end
      end

      assign live_vec[g] = live_q;
      assign done_vec[g] = done_q;
      assign misp_vec[g] = misp_q;
      assign exc_vec[g]  = exc_q;
      assign kind_arr[g] = kind_q;
      assign dest_arr[g] = dest_q;
      assign val_arr[g]  = val_q;
   end

   assign head_valid = live_vec[head_idx];
   assign head_ready = done_vec[head_idx];
   assign head_misp  = misp_vec[head_idx];
   assign head_exc   = exc_vec[head_idx];
   assign head_kind  = rob_kind_e'(kind_arr[head_idx]);
   assign head_dest  = dest_arr[head_idx];
   assign head_value = val_arr[head_idx];
endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
   import rob_pkg::*;
(
   input  logic      head_valid,
   input  logic      head_ready,
   input  rob_kind_e head_kind,
   input  logic      head_misp,
   input  logic      head_exc,
   output logic      commit_fire,
   output logic      flush,
   output logic      rf_we,
   output logic      mem_we,
   output logic      redirect_valid,
   output logic      trap_valid
);
   logic clean;

   always_comb begin
      commit_fire    = head_valid && head_ready;
      clean          = commit_fire && !head_exc;
      trap_valid     = commit_fire && head_exc;
      rf_we          = clean && (head_kind == KIND_REG);
      mem_we         = clean && (head_kind == KIND_STORE);
      redirect_valid = clean && (head_kind == KIND_BRANCH) && head_misp;
      flush          = trap_valid || redirect_valid;
   end
endmodule

// File: rtl/rob_top.sv
module rob_top
   import rob_pkg::*;
#(
   parameter  int DEPTH  = 8,
   parameter  int DATA_W = 32,
   parameter  int DEST_W = 5,
   localparam int TAG_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [1:0]        alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   output logic [TAG_W-1:0]  alloc_tag,
   output logic              full,
   input  logic              cmp_valid,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              cmp_mispredict,
   input  logic              cmp_except,
   output logic              commit_valid,
   output logic [TAG_W-1:0]  commit_tag,
   output logic              rf_we,
   output logic [DEST_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              mem_we,
   output logic [DEST_W-1:0] mem_slot,
   output logic [DATA_W-1:0] mem_data,
   output logic              redirect_valid,
   output logic [DATA_W-1:0] redirect_pc,
   output logic              trap_valid
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_top: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1 || DEST_W < 1) begin : g_bad_width
      $error("rob_top: DATA_W and DEST_W must be positive");
   end

   logic [TAG_W-1:0]  head, tail;
   logic [CNT_W-1:0]  count;
   logic              alloc_fire, commit_fire, flush;
   logic              head_valid, head_ready, head_misp, head_exc;
   rob_kind_e         head_kind;
   logic [DEST_W-1:0] head_dest;
   logic [DATA_W-1:0] head_value;

   assign full       = (count == CNT_W'(DEPTH));
   assign alloc_fire = alloc_valid && !full && !flush;
   assign alloc_tag  = tail;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .commit_fire (commit_fire),
      .flush       (flush),
      .head        (head),
      .tail        (tail),
      .count       (count)
   );

   rob_entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_idx  (tail),
      .alloc_kind (rob_kind_e'(alloc_kind)),
      .alloc_dest (alloc_dest),
      .cmp_valid  (cmp_valid),
      .cmp_idx    (cmp_tag),
      .cmp_value  (cmp_value),
      .cmp_misp   (cmp_mispredict),
      .cmp_exc    (cmp_except),
      .retire     (commit_fire),
      .flush      (flush),
      .head_idx   (head),
      .head_valid (head_valid),
      .head_ready (head_ready),
      .head_kind  (head_kind),
      .head_dest  (head_dest),
      .head_value (head_value),
      .head_misp  (head_misp),
      .head_exc   (head_exc)
   );

   rob_commit_unit u_commit (
      .head_valid     (head_valid),
      .head_ready     (head_ready),
      .head_kind      (head_kind),
      .head_misp      (head_misp),
      .head_exc       (head_exc),
      .commit_fire    (commit_fire),
      .flush          (flush),
      .rf_we          (rf_we),
      .mem_we         (mem_we),
      .redirect_valid (redirect_valid),
      .trap_valid     (trap_valid)
   );

   assign commit_valid = commit_fire;
   assign commit_tag   = head;
   assign rf_addr      = head_dest;
   assign rf_data      = head_value;
   assign mem_slot     = head_dest;
   assign mem_data     = head_value;
   assign redirect_pc  = head_value;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
   parameter  int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic [TAG_W-1:0] tail,
   input logic             full,
   input logic             alloc_valid,
   input logic             flush,
   input logic             commit_valid,
   input logic             rf_we,
   input logic             mem_we,
   input logic             redirect_valid,
   input logic             trap_valid
);
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_full_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> (tail == $past(tail)));

   assert_alloc_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !full && !flush) |=> (tail == TAG_W'($past(tail) + 1'b1)));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   assert_empty_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !commit_valid);

   assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we, mem_we, redirect_valid, trap_valid}));
endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH)) u_rob_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .count          (count),
   .tail           (tail),
   .full           (full),
   .alloc_valid    (alloc_valid),
   .flush          (flush),
   .commit_valid   (commit_valid),
   .rf_we          (rf_we),
   .mem_we         (mem_we),
   .redirect_valid (redirect_valid),
   .trap_valid     (trap_valid)
);

// File: tb/tb_rob_top.sv
module tb_rob_top;
   localparam int DEPTH = 8;
   localparam int DATA_W = 32;
   localparam int DEST_W = 5;
   localparam int TAG_W = 3;
   localparam int NVEC = 6;

   // row: {kind[1:0], dest[4:0], value[31:0]}; kind 0 reg, 1 store, 2 branch
   localparam logic [38:0] VEC [NVEC] = '{
      {2'd0, 5'd3,  32'h0000_0011},
      {2'd1, 5'd5,  32'h0000_0022},
      {2'd0, 5'd7,  32'h0000_0033},
      {2'd2, 5'd0,  32'h0000_0044},
      {2'd0, 5'd31, 32'h0000_0055},
      {2'd1, 5'd1,  32'h0000_0066}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0;
   logic [1:0] alloc_kind = '0;
   logic [DEST_W-1:0] alloc_dest = '0;
   logic cmp_valid = 1'b0;
   logic [TAG_W-1:0] cmp_tag = '0;
   logic [DATA_W-1:0] cmp_value = '0;
   logic cmp_mispredict = 1'b0;
   logic cmp_except = 1'b0;
   logic [TAG_W-1:0] alloc_tag, commit_tag;
   logic full, commit_valid, rf_we, mem_we, redirect_valid, trap_valid;
   logic [DEST_W-1:0] rf_addr, mem_slot;
   logic [DATA_W-1:0] rf_data, mem_data, redirect_pc;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rob_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
      .alloc_tag(alloc_tag), .full(full),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
      .cmp_mispredict(cmp_mispredict), .cmp_except(cmp_except),
      .commit_valid(commit_valid), .commit_tag(commit_tag),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .mem_we(mem_we), .mem_slot(mem_slot), .mem_data(mem_data),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .trap_valid(trap_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      alloc_valid = 1'b0;
      cmp_valid = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic do_alloc(input logic [1:0] kind, input logic [DEST_W-1:0] dest);
      alloc_valid = 1'b1;
      alloc_kind = kind;
      alloc_dest = dest;
      tick();
      alloc_valid = 1'b0;
   endtask

   task automatic do_cmp(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val,
                         input logic misp, input logic exc);
      cmp_valid = 1'b1;
      cmp_tag = tag;
      cmp_value = val;
      cmp_mispredict = misp;
      cmp_except = exc;
      tick();
      cmp_valid = 1'b0;
      cmp_mispredict = 1'b0;
      cmp_except = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      check("R1 full", full, 0);
      check("R1 alloc_tag", alloc_tag, 0);
      check("R1 commit_valid", commit_valid, 0);
      check("R1 rf_we", rf_we, 0);

      // table walk: dispatch in order, complete in reverse, retire in order
      for (int i = 0; i < NVEC; i++) begin
         check("R2 tag order", alloc_tag, i);
         do_alloc(VEC[i][38:37], VEC[i][36:32]);
      end
      for (int i = NVEC - 1; i >= 0; i--) begin
         do_cmp(TAG_W'(i), VEC[i][31:0], 1'b0, 1'b0);
         if (i > 0) check("R4 younger waits", commit_valid, 0);
      end
      for (int i = 0; i < NVEC; i++) begin
         check("R4 in-order tag", commit_tag, i);
         check("R4 commit_valid", commit_valid, 1);
         case (VEC[i][38:37])
            2'd0: begin
               check("R5 rf_we", rf_we, 1);
               check("R5 rf_addr", rf_addr, VEC[i][36:32]);
               check("R5 rf_data", rf_data, VEC[i][31:0]);
               check("R5 mem_we", mem_we, 0);
            end
            2'd1: begin
               check("R6 mem_we", mem_we, 1);
               check("R6 mem_slot", mem_slot, VEC[i][36:32]);
               check("R6 mem_data", mem_data, VEC[i][31:0]);
               check("R6 rf_we", rf_we, 0);
            end
            default: begin
               check("R7 rf_we", rf_we, 0);
               check("R7 mem_we", mem_we, 0);
               check("R7 redirect", redirect_valid, 0);
            end
         endcase
         tick();
      end
      check("R4 drained", commit_valid, 0);
      check("R2 tag after table", alloc_tag, NVEC);

      // R3: full stall
      do_reset();
      for (int i = 0; i < DEPTH; i++) do_alloc(2'd0, DEST_W'(i));
      check("R3 full set", full, 1);
      check("R3 tag wrapped", alloc_tag, 0);
      do_alloc(2'd0, 5'd20);
      check("R3 full held", full, 1);
      check("R3 tag unchanged", alloc_tag, 0);
      do_cmp(3'd0, 32'hAB, 1'b0, 1'b0);
      check("R3 oldest retires", commit_tag, 0);
      check("R3 oldest dest kept", rf_addr, 0);
      check("R3 data", rf_data, 32'hAB);
      tick();
      check("R3 full cleared", full, 0);
      check("R3 tag after retire", alloc_tag, 0);

      // R8, R11, R10: mispredicted branch
      do_reset();
      do_alloc(2'd0, 5'd1);
      do_alloc(2'd2, 5'd0);
      do_alloc(2'd0, 5'd2);
      do_alloc(2'd0, 5'd3);
      do_cmp(3'd2, 32'h22, 1'b0, 1'b0);
      check("R4 wait behind head", commit_valid, 0);
      do_cmp(3'd3, 32'h33, 1'b0, 1'b0);
      do_cmp(3'd0, 32'h10, 1'b0, 1'b0);
      check("R5 head reg", rf_we, 1);
      do_cmp(3'd1, 32'h1000, 1'b1, 1'b0);
      check("R8 redirect_valid", redirect_valid, 1);
      check("R8 redirect_pc", redirect_pc, 32'h1000);
      check("R8 commit_tag", commit_tag, 1);
      check("R8 no rf write", rf_we, 0);
      check("R8 no trap", trap_valid, 0);
      do_alloc(2'd0, 5'd9);
      check("R8 younger discarded", commit_valid, 0);
      check("R11 alloc in flush dropped", alloc_tag, 2);
      check("R8 not full", full, 0);
      do_alloc(2'd0, 5'd9);
      do_cmp(3'd3, 32'h77, 1'b0, 1'b0);
      do_alloc(2'd0, 5'd10);
      do_cmp(3'd2, 32'h88, 1'b0, 1'b0);
      check("R10 new tag2 commits", commit_tag, 2);
      check("R10 rf_addr", rf_addr, 9);
      check("R10 rf_data", rf_data, 32'h88);
      tick();
      check("R10 stale completion ignored", commit_valid, 0);

      // R9: exception at head
      do_reset();
      do_alloc(2'd0, 5'd4);
      do_alloc(2'd1, 5'd2);
      do_cmp(3'd1, 32'h55, 1'b0, 1'b0);
      check("R9 held while not head", trap_valid, 0);
      do_cmp(3'd0, 32'h66, 1'b0, 1'b1);
      check("R9 trap_valid", trap_valid, 1);
      check("R9 trap tag", commit_tag, 0);
      check("R9 no rf write", rf_we, 0);
      tick();
      check("R9 buffer emptied", commit_valid, 0);
      check("R9 store dropped", mem_we, 0);
      check("R9 tag after trap", alloc_tag, 1);
      do_alloc(2'd2, 5'd0);
      do_cmp(3'd1, 32'h500, 1'b1, 1'b1);
      check("R9 trap wins", trap_valid, 1);
      check("R9 no redirect", redirect_valid, 0);
      tick();
      check("R9 tag after branch trap", alloc_tag, 2);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule